// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Registers

This block holds one message-signalled interrupt capability as a small register window in configuration space. Software reaches it through byte offsets. It can read a control word, a message address of 32 or 64 bits, a message data word and an optional mask with one bit per vector. Whether the upper address word and the mask exist is fixed by parameters at elaboration. The positions of the data and mask registers move with those choices.

Interrupt sources inside the device raise a request with a vector index. If the capability is enabled, the vector lies within the enabled count and its mask bit is clear, the block emits one memory-write message. The message carries the programmed address and the base data with the vector index ORed into its low bits. It is presented on a valid/ready output and holds there until it is taken. A request that is not allowed is dropped and leaves no pending state. The block also reports the length of its structure and carries a next-capability pointer for the list walker.

Top module: `msi_cap_regs`

## Requirements
- R1: Dword 0 reads as {control[15:0], next pointer, 8'h05}. In the control word, bit 0 is enable, bits 3:1 are the vector-count capability, bits 6:4 are the enabled vector count (as a power of two), bit 7 is 64-bit capable, bit 8 is mask capable, bit 9 is wide-data capable and bit 10 is wide-data enable. Bits 1-3 and 7-9 come from parameters and ignore writes.
- R2: `cap_len` equals 12, plus 4 when 64-bit addressing is present, plus 8 when masking is present.
- R3: The enabled-count field takes a written value only when the block is disabled or the same write disables it. The stored value is the smaller of the written value and the capability.
- R4: Wide-data enable can become 1 only when wide-data capable is 1.
- R5: A 2-byte write to the data register replaces only bits 15:0. A 4-byte write replaces all 32 bits only when wide-data capable is 1; otherwise it also replaces only bits 15:0.
- R6: With 64-bit addressing, the upper address is at 0x08, data at 0x0C and mask at 0x10. Without it, data is at 0x08 and mask at 0x0C. The lower address is at 0x04 in both layouts.
- R7: A request for vector i emits a message only when enable is 1, i < 2^(enabled count) and mask bit i is 0. The message data is the base data ORed with i, truncated to 16 bits unless wide-data enable is 1.
- R8: The message address is {upper, lower} with 64-bit addressing and the lower word alone otherwise.
- R9: An emitted message keeps valid, address and data stable until ready is seen. Requests arriving while it is held are dropped, and `req_ready` reads 0 during that time.
- R10: Reset clears enable and all stored fields.
- R11: Writes to offsets or sizes that map to no register change nothing. Reads of dwords outside the defined registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_wide | input | 1 | 1 = 4-byte write, 0 = 2-byte write |
| wr_data | input | 32 | Write data; a 2-byte write uses bits 15:0 |
| rd_addr | input | 8 | Byte offset of the read, dword granular |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| cap_len | output | 8 | Structure length in bytes |
| vec_req | input | 1 | Vector request |
| vec_idx | input | IDX_W | Requested vector index |
| req_ready | output | 1 | High when no message is being held |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message taken by the consumer |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Two instances are driven. One has 64-bit addressing, masking and wide-data capability. The other has 32-bit addressing, masking and no wide data, so the shifted register layout and the 16-bit truncation of data writes are each seen against a layout where they do not apply. Vector requests cover the lowest and highest in-range indices, a masked index, an index just past the enabled count, and a request while disabled. Each separates one term of the fire condition from the others. Control writes try to change the vector count while enabled, while disabling, and above the capability, which tells the guard rule apart from the clamp. A message held back by a low ready, with a second request issued under it, shows stability and dropping together.

// File: rtl/msi_cap_pkg.sv
// Shared constants for the message-signalled interrupt capability.
// Assumes a single capability instance per function.
package msi_cap_pkg;
    localparam logic [7:0] CAP_ID_MSI = 8'h05;
    localparam int         CTRL_W     = 16;
    localparam int         MASK_W     = 32;
    localparam int         DW         = 32;

    // Structure length from the layout choices.
    function automatic logic [7:0] cap_bytes(input bit a64, input bit msk);
        return 8'd12 + (a64 ? 8'd4 : 8'd0) + (msk ? 8'd8 : 8'd0);
    endfunction
endpackage

// File: rtl/msi_ctrl_reg.sv
// Control state: enable, enabled vector count and wide-data enable.
// Assumes the write decoder hands over one 16-bit control word per strobe.
module msi_ctrl_reg #(
    parameter int MMC     = 3,
    parameter bit EXT_CAP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] word,
    output logic        en,
    output logic [2:0]  mme,
    output logic        ext_en
);
    localparam logic [2:0] MMC_V = 3'(MMC);

    logic       new_en;
    logic [2:0] new_mme;
    assign new_en  = word[0];
    assign new_mme = (word[6:4] > MMC_V) ? MMC_V : word[6:4];

    // Apply guarded control writes; reset clears all fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            mme    <= 3'd0;
            ext_en <= 1'b0;
        end else if (we) begin
            if (!en || !new_en) mme <= new_mme;
            ext_en <= EXT_CAP & word[10];
            en     <= new_en;
        end
    end

    p_mme_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mme <= MMC_V);
    p_mme_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (!en || $stable(mme)));
    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (!en && !ext_en));
endmodule

// File: rtl/msi_msg_store.sv
// Write decode and storage for address, data and mask registers.
// Assumes aligned offsets; anything that matches no register is dropped.
module msi_msg_store #(
    parameter bit ADDR64   = 1'b1,
    parameter bit MASK_CAP = 1'b1,
    parameter bit EXT_CAP  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic        wr_wide,
    input  logic [31:0] wr_data,
    output logic        ctrl_we,
    output logic [15:0] ctrl_word,
    output logic [31:0] addr_lo,
    output logic [31:0] addr_hi,
    output logic [31:0] data,
    output logic [31:0] mask
);
    localparam logic [7:0] DATA_OFF = ADDR64 ? 8'h0C : 8'h08;
    localparam logic [7:0] MASK_OFF = ADDR64 ? 8'h10 : 8'h0C;

    logic lo_we, data_we;
    assign ctrl_we   = wr_en && ((wr_addr == 8'h00 && wr_wide) || (wr_addr == 8'h02 && !wr_wide));
    assign ctrl_word = wr_wide ? wr_data[31:16] : wr_data[15:0];
    assign lo_we     = wr_en && wr_wide && (wr_addr == 8'h04);
    assign data_we   = wr_en && (wr_addr == DATA_OFF);

    // Lower address and data registers, present in every layout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo <= '0;
            data    <= '0;
        end else begin
            if (lo_we) addr_lo <= wr_data;
            if (data_we) begin
                if (wr_wide && EXT_CAP) data <= wr_data;
                else                    data <= {data[31:16], wr_data[15:0]};
            end
        end
    end

    generate
        if (ADDR64) begin : g_hi
            // Upper address word, only with 64-bit addressing.
            always_ff @(posedge clk) begin
                if (!rst_n) addr_hi <= '0;
                else if (wr_en && wr_wide && wr_addr == 8'h08) addr_hi <= wr_data;
            end
        end else begin : g_no_hi
            assign addr_hi = '0;
        end
        if (MASK_CAP) begin : g_mask
            // Per-vector mask, only when masking is supported.
            always_ff @(posedge clk) begin
                if (!rst_n) mask <= '0;
                else if (wr_en && wr_wide && wr_addr == MASK_OFF) mask <= wr_data;
            end
        end else begin : g_no_mask
            assign mask = '0;
        end
    endgenerate

    p_data_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !wr_wide) |=> data[31:16] == $past(data[31:16]));
endmodule

// File: rtl/msi_vec_gate.sv
// Qualifies vector requests and holds one outgoing message until taken.
// Assumes the index is narrower than or equal to the mask width.
module msi_vec_gate #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [2:0]       mme,
    input  logic             ext_en,
    input  logic [31:0]      mask,
    input  logic [63:0]      base_addr,
    input  logic [31:0]      base_data,
    input  logic             vec_req,
    input  logic [IDX_W-1:0] vec_idx,
    output logic             req_ready,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [63:0]      msg_addr,
    output logic [31:0]      msg_data
);
    localparam int CMP_W = IDX_W + 8;

    logic        in_range, allow, accept;
    logic [31:0] idx_ext, vec_data;
    assign idx_ext   = 32'(vec_idx);
    assign in_range  = CMP_W'(vec_idx) < (CMP_W'(1) << mme);
    assign allow     = en && in_range && !mask[vec_idx];
    assign req_ready = !msg_valid;
    assign accept    = vec_req && req_ready && allow;
    assign vec_data  = ext_en ? (base_data | idx_ext) : {16'h0, base_data[15:0] | idx_ext[15:0]};

    // Load a message on an allowed request; drop it once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (accept) begin
            msg_valid <= 1'b1;
            msg_addr  <= base_addr;
            msg_data  <= vec_data;
        end else if (msg_valid && msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
    p_fire_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(en));
endmodule

// File: rtl/msi_cap_regs.sv
// Message-signalled interrupt capability: register window plus message emitter.
// Assumes dword-granular reads and a configuration walker that uses cap_len.
module msi_cap_regs #(
    parameter bit         ADDR64   = 1'b1,
    parameter bit         MASK_CAP = 1'b1,
    parameter bit         EXT_CAP  = 1'b1,
    parameter int         MMC      = 3,
    parameter logic [7:0] NEXT_PTR = 8'h60,
    parameter int         IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic             wr_wide,
    input  logic [31:0]      wr_data,
    input  logic [7:0]       rd_addr,
    output logic [31:0]      rd_data,
    output logic [7:0]       cap_len,
    input  logic             vec_req,
    input  logic [IDX_W-1:0] vec_idx,
    output logic             req_ready,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [63:0]      msg_addr,
    output logic [31:0]      msg_data
);
    import msi_cap_pkg::*;

    logic        en, ext_en, ctrl_we;
    logic [2:0]  mme;
    logic [15:0] ctrl_word, ctrl;
    logic [31:0] addr_lo, addr_hi, data, mask;
    logic [63:0] base_addr;

    assign cap_len   = cap_bytes(ADDR64, MASK_CAP);
    assign ctrl      = {5'b0, ext_en, EXT_CAP, MASK_CAP, ADDR64, mme, 3'(MMC), en};
    assign base_addr = ADDR64 ? {addr_hi, addr_lo} : {32'h0, addr_lo};

    msi_msg_store #(.ADDR64(ADDR64), .MASK_CAP(MASK_CAP), .EXT_CAP(EXT_CAP)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide),
        .wr_data(wr_data), .ctrl_we(ctrl_we), .ctrl_word(ctrl_word), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .data(data), .mask(mask)
    );

    msi_ctrl_reg #(.MMC(MMC), .EXT_CAP(EXT_CAP)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .word(ctrl_word),
        .en(en), .mme(mme), .ext_en(ext_en)
    );

    msi_vec_gate #(.IDX_W(IDX_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .en(en), .mme(mme), .ext_en(ext_en), .mask(mask),
        .base_addr(base_addr), .base_data(data), .vec_req(vec_req), .vec_idx(vec_idx),
        .req_ready(req_ready), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Read mux over the dword layout chosen by the parameters.
    always_comb begin
        unique case (rd_addr[7:2])
            6'd0:    rd_data = {ctrl, NEXT_PTR, CAP_ID_MSI};
            6'd1:    rd_data = addr_lo;
            6'd2:    rd_data = ADDR64 ? addr_hi : data;
            6'd3:    rd_data = ADDR64 ? data : mask;
            6'd4:    rd_data = ADDR64 ? mask : 32'h0;
            default: rd_data = 32'h0;
        endcase
    end

    p_ext_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_en) |-> (ctrl[9] && $past(ctrl_we)));
endmodule

// File: tb/msi_cap_regs_test.sv
module msi_cap_regs_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en_a = 1'b0, wr_en_b = 1'b0, wr_wide = 1'b0;
    logic [7:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_a, rd_b;
    logic [7:0] len_a, len_b;
    logic req_a = 1'b0, req_b = 1'b0;
    logic [4:0] idx_a = '0, idx_b = '0;
    logic rdy_a, rdy_b, val_a, val_b;
    logic mrdy_a = 1'b1, mrdy_b = 1'b1;
    logic [63:0] addr_a, addr_b;
    logic [31:0] data_a, data_b;
    int total = 0, bad = 0;
    logic [95:0] q_a[$];
    logic [95:0] q_b[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_cap_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_a), .wr_addr(wr_addr), .wr_wide(wr_wide),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_a), .cap_len(len_a),
        .vec_req(req_a), .vec_idx(idx_a), .req_ready(rdy_a), .msg_valid(val_a),
        .msg_ready(mrdy_a), .msg_addr(addr_a), .msg_data(data_a));

    msi_cap_regs #(.ADDR64(1'b0), .MASK_CAP(1'b1), .EXT_CAP(1'b0), .MMC(2)) uut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_b), .wr_addr(wr_addr), .wr_wide(wr_wide),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_b), .cap_len(len_b),
        .vec_req(req_b), .vec_idx(idx_b), .req_ready(rdy_b), .msg_valid(val_b),
        .msg_ready(mrdy_b), .msg_addr(addr_b), .msg_data(data_b));

    task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Register write to instance a (sel=0) or b (sel=1).
    task automatic wr(input bit sel, input logic [7:0] a, input bit wide, input logic [31:0] d);
        @(negedge clk);
        wr_addr = a; wr_wide = wide; wr_data = d;
        if (sel) wr_en_b = 1'b1; else wr_en_a = 1'b1;
        @(negedge clk);
        wr_en_a = 1'b0; wr_en_b = 1'b0;
    endtask

    task automatic rd_chk(input bit sel, input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        if (sel) check(rd_b == exp, tag, 96'(rd_b), 96'(exp));
        else     check(rd_a == exp, tag, 96'(rd_a), 96'(exp));
    endtask

    // Driver: wait for an idle output, pulse a request, push the expectation.
    task automatic send(input bit sel, input logic [4:0] i, input bit fire,
                        input logic [63:0] ea, input logic [31:0] ed);
        @(negedge clk);
        while (sel ? !rdy_b : !rdy_a) @(negedge clk);
        if (sel) begin req_b = 1'b1; idx_b = i; end
        else     begin req_a = 1'b1; idx_a = i; end
        if (fire) begin
            if (sel) q_b.push_back({ea, ed}); else q_a.push_back({ea, ed});
        end
        @(negedge clk);
        req_a = 1'b0; req_b = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitors: pop and compare at each handshake.
    always @(negedge clk) begin
        if (rst_n && val_a && mrdy_a) begin
            if (q_a.size() == 0) check(1'b0, "R7 unexpected message a", {addr_a, data_a}, 96'h0);
            else begin
                logic [95:0] e;
                e = q_a.pop_front();
                check({addr_a, data_a} == e, "R7 R8 message a", {addr_a, data_a}, e);
            end
        end
        if (rst_n && val_b && mrdy_b) begin
            if (q_b.size() == 0) check(1'b0, "R7 unexpected message b", {addr_b, data_b}, 96'h0);
            else begin
                logic [95:0] e;
                e = q_b.pop_front();
                check({addr_b, data_b} == e, "R7 R8 message b", {addr_b, data_b}, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "watchdog", 96'h0, 96'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R2 reset state
        rd_chk(0, 8'h00, 32'h0386_6005, "R1 dword0 a after reset");
        rd_chk(1, 8'h00, 32'h0104_6005, "R1 dword0 b after reset");
        check(len_a == 8'd24, "R2 len a", 96'(len_a), 96'd24);
        check(len_b == 8'd20, "R2 len b", 96'(len_b), 96'd20);
        check(!val_a && rdy_a, "R10 idle after reset", 96'({val_a, rdy_a}), 96'h1);

        // R6 layout with 64-bit addressing
        wr(0, 8'h04, 1, 32'hFEE0_1000);
        wr(0, 8'h08, 1, 32'h0000_0001);
        wr(0, 8'h0C, 1, 32'hABCD_1230);
        wr(0, 8'h10, 1, 32'h0000_0004);
        rd_chk(0, 8'h04, 32'hFEE0_1000, "R6 addr lo a");
        rd_chk(0, 8'h08, 32'h0000_0001, "R6 addr hi a");
        rd_chk(0, 8'h0C, 32'hABCD_1230, "R5 R6 wide data kept a");
        rd_chk(0, 8'h10, 32'h0000_0004, "R6 mask a");

        // R3 enable with count 3, then try changing while enabled
        wr(0, 8'h02, 0, 32'h0000_0031);
        rd_chk(0, 8'h00, 32'h03B7_6005, "R3 enable with count");
        wr(0, 8'h02, 0, 32'h0000_0011);
        rd_chk(0, 8'h00, 32'h03B7_6005, "R3 count held while enabled");

        // R7 R8 fire patterns, 16-bit data
        send(0, 5'd0, 1, 64'h1_FEE0_1000, 32'h0000_1230);
        send(0, 5'd3, 1, 64'h1_FEE0_1000, 32'h0000_1233);
        send(0, 5'd2, 0, 64'h0, 32'h0);
        send(0, 5'd7, 1, 64'h1_FEE0_1000, 32'h0000_1237);
        send(0, 5'd8, 0, 64'h0, 32'h0);
        check(q_a.size() == 0, "R7 masked and out-of-range dropped", 96'(q_a.size()), 96'h0);

        // R4 wide-data enable via 4-byte control write
        wr(0, 8'h00, 1, 32'h0401_0000);
        rd_chk(0, 8'h00, 32'h07B7_6005, "R4 wide data enabled");
        send(0, 5'd1, 1, 64'h1_FEE0_1000, 32'hABCD_1231);

        // R5 narrow data write keeps upper half
        wr(0, 8'h0C, 0, 32'h0000_5550);
        rd_chk(0, 8'h0C, 32'hABCD_5550, "R5 narrow data write");

        // R3 disable with clamp, then change count while disabled
        wr(0, 8'h02, 0, 32'h0000_0050);
        rd_chk(0, 8'h00, 32'h03B6_6005, "R3 clamp on disabling write");
        wr(0, 8'h02, 0, 32'h0000_0010);
        rd_chk(0, 8'h00, 32'h0396_6005, "R3 count change while disabled");
        send(0, 5'd0, 0, 64'h0, 32'h0);
        wr(0, 8'h02, 0, 32'h0000_0011);
        send(0, 5'd1, 1, 64'h1_FEE0_1000, 32'h0000_5551);
        send(0, 5'd2, 0, 64'h0, 32'h0);
        check(q_a.size() == 0, "R7 disabled and over-count dropped", 96'(q_a.size()), 96'h0);

        // R11 unmapped writes and reads
        wr(0, 8'h14, 1, 32'hFFFF_FFFF);
        wr(0, 8'h04, 0, 32'h0000_FFFF);
        wr(0, 8'h06, 0, 32'h0000_FFFF);
        rd_chk(0, 8'h04, 32'hFEE0_1000, "R11 ignored writes leave addr");
        rd_chk(0, 8'h14, 32'h0, "R11 read outside is zero");

        // R1 capability bits read-only
        wr(0, 8'h02, 0, 32'h0000_0B8E);
        rd_chk(0, 8'h00, 32'h0386_6005, "R1 capability bits read-only");

        // R9 hold under low ready and drop under hold
        wr(0, 8'h02, 0, 32'h0000_0001);
        mrdy_a = 1'b0;
        q_a.push_back({64'h1_FEE0_1000, 32'h0000_5550});
        @(negedge clk); req_a = 1'b1; idx_a = 5'd0;
        @(negedge clk); req_a = 1'b0;
        repeat (2) @(negedge clk);
        req_a = 1'b1; idx_a = 5'd0;
        @(negedge clk); req_a = 1'b0;
        check(val_a && !rdy_a, "R9 held with ready low", 96'({val_a, rdy_a}), 96'h2);
        check(data_a == 32'h0000_5550, "R9 data stable", 96'(data_a), 96'h5550);
        mrdy_a = 1'b1;
        repeat (4) @(negedge clk);
        check(q_a.size() == 0 && !val_a, "R9 one message only", 96'(q_a.size()), 96'h0);

        // Instance b: 32-bit layout, no wide data
        wr(1, 8'h04, 1, 32'h0000_2000);
        wr(1, 8'h08, 1, 32'h1234_5670);
        wr(1, 8'h0C, 1, 32'h0000_0001);
        rd_chk(1, 8'h08, 32'h0000_5670, "R5 R6 wide write truncated b");
        rd_chk(1, 8'h0C, 32'h0000_0001, "R6 mask at 0x0C b");
        rd_chk(1, 8'h10, 32'h0, "R11 pending area reads zero b");
        wr(1, 8'h02, 0, 32'h0000_0421);
        rd_chk(1, 8'h00, 32'h0125_6005, "R4 wide enable refused b");
        send(1, 5'd0, 0, 64'h0, 32'h0);
        send(1, 5'd3, 1, 64'h0000_0000_0000_2000, 32'h0000_5673);
        send(1, 5'd4, 0, 64'h0, 32'h0);
        check(q_b.size() == 0, "R8 32-bit messages done b", 96'(q_b.size()), 96'h0);

        // R10 reset clears
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk(0, 8'h00, 32'h0386_6005, "R10 reset clears control");
        rd_chk(0, 8'h0C, 32'h0, "R10 reset clears data");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule